// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block owns the operating mode of a CAN controller and the few configuration bits that travel with it. The controller can be in one of four modes: sleep, reset, halt and operation. Software moves it between them by writing a 16-bit control word over a simple write-only host bus. The current mode is reported on a 2-bit status output. The same word also carries the transmit priority selection, the mixed standard/extended identifier selection, and the bus-off recovery setting.

Two configuration registers sit behind the mode check. The bit-timing register accepts a write only while the controller is in reset or halt. The clock-select register accepts a write only in reset. A write made in any other mode is dropped and the old value is kept. When the controller is in operation, the recovery field is set to automatic halt, and a bus-off event arrives, the block moves itself to halt without any help from software.

After a power-on or software reset the block sits in sleep. To wake it, software clears the sleep bit, which lands the block in reset. Clearing the reset/halt field then takes it to operation.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the block reports sleep (`mode_o`=3) and holds bit timing 0, clock select 0, recovery field 0, transmit priority 0 and mixed ID 0.
- R2: In sleep, a control write (address 0) with bit 10 clear gives reset (`mode_o`=1) on the next cycle. A control write with bit 10 set, or no control write at all, leaves the block in sleep.
- R3: A control write with bit 10 set enters sleep only when the current mode is reset. In halt or operation, bit 10 is ignored and the mode follows bits 9:8 as in R4.
- R4: When not in sleep, a control write takes effect one cycle later, using bits 9:8. The value 00 gives operation (0). The value 10 gives halt (2). The values 01 and 11 give reset (1).
- R5: In operation, a bus-off pulse while the stored recovery field (bits 12:11) is 01 gives halt on the next cycle, even if a control write arrives in the same cycle. With any other recovery value, or in any other mode, bus-off has no effect on the mode.
- R6: A write to the bit-timing register (address 1) is stored only when the current mode is reset or halt. Otherwise the register keeps its old value.
- R7: A write to the clock-select register (address 2) is stored only when the current mode is reset. In halt, operation or sleep the register keeps its old value.
- R8: Every control write captures bit 4 (transmit priority by mailbox number), bit 2 (mixed ID format) and bits 12:11 (recovery field). These appear on their outputs one cycle later, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W (2) | Register select: 0 control, 1 bit timing, 2 clock select |
| host_wdata | input | DATA_W (16) | Write data |
| bus_off_i | input | 1 | Bus-off entry event from the protocol engine |
| mode_o | output | 2 | Current mode: 0 operation, 1 reset, 2 halt, 3 sleep |
| bit_timing_o | output | BT_W (16) | Bit-timing register contents |
| clk_sel_o | output | CS_W (8) | Clock-select register contents |
| tx_prio_o | output | 1 | Transmit priority by mailbox number |
| id_mixed_o | output | 1 | Mixed standard/extended ID mode |
| busoff_mode_o | output | 2 | Stored bus-off recovery field |

## Verification
Every result of this block appears exactly one clock after the edge that samples the write or the bus-off pulse. There are no multi-cycle paths. The mode gating of the registers always uses the mode that held before that edge, not the one being entered. The bench drives each stimulus for one cycle starting at a falling edge. It compares all outputs against a behavioural model at every following falling edge, so each result is checked in the cycle it becomes due. Directed checks at those same falling edges pin down the expected constants for the gating, sleep and bus-off corner cases.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OPER  = 2'd0,
        MODE_RESET = 2'd1,
        MODE_HALT  = 2'd2,
        MODE_SLEEP = 2'd3
    } mode_e;

    localparam int CTL_W      = 16;
    localparam int SLP_BIT    = 10;
    localparam int HLT_BIT    = 9;
    localparam int RST_BIT    = 8;
    localparam int BOM_LO     = 11;
    localparam int TPM_BIT    = 4;
    localparam int IDM_BIT    = 2;
    localparam logic [1:0] BOM_AUTOHALT = 2'b01;

    localparam int ADDR_CTL = 0;
    localparam int ADDR_BT  = 1;
    localparam int ADDR_CS  = 2;

    // Mode masks: bit index is the mode_e value
    localparam logic [3:0] ALLOW_RST_HLT = 4'b0110;
    localparam logic [3:0] ALLOW_RST     = 4'b0010;

    typedef struct packed {
        logic [1:0] bom;
        logic       tpm;
        logic       idm;
    } ctl_cfg_t;

    typedef struct packed {
        logic       sleep;
        logic [1:0] rh;   // {halt, reset}
    } mode_req_t;

    function automatic ctl_cfg_t decode_cfg(input logic [CTL_W-1:0] w);
        ctl_cfg_t c;
        c.bom = w[BOM_LO+1:BOM_LO];
        c.tpm = w[TPM_BIT];
        c.idm = w[IDM_BIT];
        return c;
    endfunction

    function automatic mode_req_t decode_req(input logic [CTL_W-1:0] w);
        mode_req_t r;
        r.sleep = w[SLP_BIT];
        r.rh    = {w[HLT_BIT], w[RST_BIT]};
        return r;
    endfunction

    function automatic mode_e field_mode(input logic [1:0] rh);
        mode_e m;
        case (rh)
            2'b00:   m = MODE_OPER;
            2'b10:   m = MODE_HALT;
            default: m = MODE_RESET;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  mode_req_t req,
    input  logic      bus_off,
    input  logic      auto_halt,
    output mode_e     mode
);
    mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (ctl_wr) begin
            unique case (mode_q)
                MODE_SLEEP: mode_d = req.sleep ? MODE_SLEEP : MODE_RESET;
                MODE_RESET: mode_d = req.sleep ? MODE_SLEEP : field_mode(req.rh);
                default:    mode_d = field_mode(req.rh);
            endcase
        end
        if (mode_q == MODE_OPER && bus_off && auto_halt)
            mode_d = MODE_HALT;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SLEEP;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/can_ctl_cfg.sv
module can_ctl_cfg
    import can_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_wr,
    input  ctl_cfg_t cfg_in,
    output ctl_cfg_t cfg
);
    ctl_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (ctl_wr) cfg_q <= cfg_in;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/can_gated_reg.sv
module can_gated_reg
    import can_mode_pkg::*;
#(
    parameter int         W     = 8,
    parameter logic [3:0] ALLOW = 4'b0010
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  mode_e        mode,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;
    logic         permit;

    assign permit = ALLOW[mode];

    always_ff @(posedge clk) begin
        if (rst)                q_r <= '0;
        else if (wr && permit)  q_r <= wdata;
    end

    assign q = q_r;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int BT_W   = 16,
    parameter int CS_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              bus_off_i,
    output logic [1:0]        mode_o,
    output logic [BT_W-1:0]   bit_timing_o,
    output logic [CS_W-1:0]   clk_sel_o,
    output logic              tx_prio_o,
    output logic              id_mixed_o,
    output logic [1:0]        busoff_mode_o
);
    logic ctl_wr, bt_wr, cs_wr;
    mode_e    mode;
    ctl_cfg_t cfg;
    logic [CTL_W-1:0] ctl_word;

    assign ctl_word = host_wdata[CTL_W-1:0];
    assign ctl_wr = host_wr && (host_addr == ADDR_W'(ADDR_CTL));
    assign bt_wr  = host_wr && (host_addr == ADDR_W'(ADDR_BT));
    assign cs_wr  = host_wr && (host_addr == ADDR_W'(ADDR_CS));

    can_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .req       (decode_req(ctl_word)),
        .bus_off   (bus_off_i),
        .auto_halt (cfg.bom == BOM_AUTOHALT),
        .mode      (mode)
    );

    can_ctl_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .ctl_wr (ctl_wr),
        .cfg_in (decode_cfg(ctl_word)),
        .cfg    (cfg)
    );

    can_gated_reg #(.W(BT_W), .ALLOW(ALLOW_RST_HLT)) u_bt (
        .clk   (clk),
        .rst   (rst),
        .wr    (bt_wr),
        .mode  (mode),
        .wdata (host_wdata[BT_W-1:0]),
        .q     (bit_timing_o)
    );

    can_gated_reg #(.W(CS_W), .ALLOW(ALLOW_RST)) u_cs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cs_wr),
        .mode  (mode),
        .wdata (host_wdata[CS_W-1:0]),
        .q     (clk_sel_o)
    );

    assign mode_o        = mode;
    assign tx_prio_o     = cfg.tpm;
    assign id_mixed_o    = cfg.idm;
    assign busoff_mode_o = cfg.bom;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int BT_W   = 16,
    parameter int CS_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              bus_off_i,
    input logic [1:0]        mode_o,
    input logic [BT_W-1:0]   bit_timing_o,
    input logic [CS_W-1:0]   clk_sel_o,
    input logic              tx_prio_o,
    input logic              id_mixed_o,
    input logic [1:0]        busoff_mode_o
);
    logic rst_q = 1'b0;
    logic ctl_wr;
    assign ctl_wr = host_wr && (host_addr == '0);

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q && !rst)
            AST_RESET_SLEEP: assert (mode_o == 2'd3 && bit_timing_o == '0 && clk_sel_o == '0); // R1
    end

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd3 && !ctl_wr) |=> mode_o == 2'd3); // R2

    AST_SLEEP_ONLY_FROM_RESET: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 || mode_o == 2'd2) |=> mode_o != 2'd3); // R3

    AST_BUSOFF_HALT: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && bus_off_i && busoff_mode_o == 2'b01) |=> mode_o == 2'd2); // R5

    AST_BT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 || mode_o == 2'd3) |=> $stable(bit_timing_o)); // R6

    AST_CS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd1) |=> $stable(clk_sel_o)); // R7

    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (tx_prio_o == $past(host_wdata[4]) && id_mixed_o == $past(host_wdata[2]))); // R8
endmodule

bind can_mode_seq can_mode_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BT_W(BT_W), .CS_W(CS_W)
) chk_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .bus_off_i(bus_off_i), .mode_o(mode_o),
    .bit_timing_o(bit_timing_o), .clk_sel_o(clk_sel_o), .tx_prio_o(tx_prio_o),
    .id_mixed_o(id_mixed_o), .busoff_mode_o(busoff_mode_o)
);

// File: tb/can_mode_seq_tb_top.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        bus_off_i = 1'b0;
    logic [1:0]  mode_o;
    logic [15:0] bit_timing_o;
    logic [7:0]  clk_sel_o;
    logic        tx_prio_o, id_mixed_o;
    logic [1:0]  busoff_mode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode, m_bt, m_cs, m_tp, m_id, m_bom;

    always #4 clk = ~clk;

    can_mode_seq dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .bus_off_i(bus_off_i), .mode_o(mode_o),
        .bit_timing_o(bit_timing_o), .clk_sel_o(clk_sel_o), .tx_prio_o(tx_prio_o),
        .id_mixed_o(id_mixed_o), .busoff_mode_o(busoff_mode_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3; m_bt = 0; m_cs = 0; m_tp = 0; m_id = 0; m_bom = 0;
        end else begin
            int nm;
            nm = m_mode;
            if (host_wr && host_addr == 1 && (m_mode == 1 || m_mode == 2)) m_bt = host_wdata;
            if (host_wr && host_addr == 2 && m_mode == 1) m_cs = host_wdata[7:0];
            if (host_wr && host_addr == 0) begin
                if (m_mode == 3)                      nm = host_wdata[10] ? 3 : 1;
                else if (m_mode == 1 && host_wdata[10]) nm = 3;
                else if (host_wdata[9:8] == 2'b00)    nm = 0;
                else if (host_wdata[9:8] == 2'b10)    nm = 2;
                else                                  nm = 1;
            end
            if (m_mode == 0 && bus_off_i && m_bom == 1) nm = 2;
            if (host_wr && host_addr == 0) begin
                m_tp = host_wdata[4]; m_id = host_wdata[2]; m_bom = host_wdata[12:11];
            end
            m_mode = nm;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(int'(mode_o) == m_mode, "R4 model mode", mode_o, m_mode);
            check(int'(bit_timing_o) == m_bt, "R6 model bt", bit_timing_o, m_bt);
            check(int'(clk_sel_o) == m_cs, "R7 model cs", clk_sel_o, m_cs);
            check(int'(tx_prio_o) == m_tp && int'(id_mixed_o) == m_id && int'(busoff_mode_o) == m_bom,
                  "R8 model cfg", {busoff_mode_o, tx_prio_o, id_mixed_o},
                  (m_bom << 2) | (m_tp << 1) | m_id);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic bo);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; bus_off_i = bo;
        @(negedge clk);
        host_wr = 1'b0; host_addr = '0; host_wdata = '0; bus_off_i = 1'b0;
    endtask

    task automatic busoff_pulse();
        @(negedge clk);
        bus_off_i = 1'b1;
        @(negedge clk);
        bus_off_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(mode_o == 2'd3, "R1 sleep after reset", mode_o, 3);
        check(bit_timing_o == 0 && clk_sel_o == 0, "R1 regs zero", {bit_timing_o, clk_sel_o}, 0);
        check(tx_prio_o == 0 && id_mixed_o == 0 && busoff_mode_o == 0, "R1 cfg zero",
              {busoff_mode_o, tx_prio_o, id_mixed_o}, 0);

        wr(2'd1, 16'h1234, 1'b0);
        check(bit_timing_o == 16'h0, "R6 bt ignored in sleep", bit_timing_o, 0);
        wr(2'd2, 16'h0005, 1'b0);
        check(clk_sel_o == 8'h0, "R7 cs ignored in sleep", clk_sel_o, 0);

        wr(2'd0, 16'h0700, 1'b0);
        check(mode_o == 2'd3, "R2 sleep kept with sleep bit set", mode_o, 3);
        wr(2'd0, 16'h0300, 1'b0);
        check(mode_o == 2'd1, "R2 wake to reset", mode_o, 1);

        wr(2'd2, 16'h00A5, 1'b0);
        check(clk_sel_o == 8'hA5, "R7 cs written in reset", clk_sel_o, 8'hA5);
        wr(2'd1, 16'hBEEF, 1'b0);
        check(bit_timing_o == 16'hBEEF, "R6 bt written in reset", bit_timing_o, 16'hBEEF);

        wr(2'd0, 16'h0A14, 1'b0);
        check(mode_o == 2'd2, "R4 reset to halt", mode_o, 2);
        check(tx_prio_o && id_mixed_o && busoff_mode_o == 2'b01, "R8 cfg captured",
              {busoff_mode_o, tx_prio_o, id_mixed_o}, 7);

        wr(2'd2, 16'h003C, 1'b0);
        check(clk_sel_o == 8'hA5, "R7 cs ignored in halt", clk_sel_o, 8'hA5);
        wr(2'd1, 16'h1111, 1'b0);
        check(bit_timing_o == 16'h1111, "R6 bt written in halt", bit_timing_o, 16'h1111);

        wr(2'd0, 16'h0814, 1'b0);
        check(mode_o == 2'd0, "R4 halt to operation", mode_o, 0);
        wr(2'd1, 16'h2222, 1'b0);
        check(bit_timing_o == 16'h1111, "R6 bt ignored in operation", bit_timing_o, 16'h1111);

        busoff_pulse();
        check(mode_o == 2'd2, "R5 bus-off auto halt", mode_o, 2);

        wr(2'd0, 16'h1014, 1'b0);
        check(mode_o == 2'd0 && busoff_mode_o == 2'b10, "R4 operation with bom 10", mode_o, 0);
        busoff_pulse();
        check(mode_o == 2'd0, "R5 bus-off ignored without auto halt", mode_o, 0);

        wr(2'd0, 16'h0814, 1'b0);
        wr(2'd0, 16'h0114, 1'b1);
        check(mode_o == 2'd2, "R5 bus-off beats same-cycle write", mode_o, 2);
        check(busoff_mode_o == 2'b00, "R8 bom still captured", busoff_mode_o, 0);

        wr(2'd0, 16'h0600, 1'b0);
        check(mode_o == 2'd2, "R3 sleep bit ignored in halt", mode_o, 2);
        wr(2'd0, 16'h0700, 1'b0);
        check(mode_o == 2'd1, "R3 forced reset from halt", mode_o, 1);
        wr(2'd0, 16'h0700, 1'b0);
        check(mode_o == 2'd3, "R3 sleep from reset", mode_o, 3);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule